// File: doc/BRIEF.md
# I2C Slave Masked Address Matcher

This block decides whether an I2C slave acknowledges the address phase of a transfer. An upstream byte receiver hands it each received byte with a one-cycle valid strobe. The block compares the address against a stored own address. A 5-bit don't-care mask lets one slave answer a whole set of addresses. The block returns a registered acknowledge decision, a full-match flag, the R/W bit of the first byte, and the received address that produced the last full match. Software reads that address to learn which of the masked addresses was used.

In 7-bit mode the first byte after idle is the whole address. In 10-bit mode the first byte must be the header `11110`, followed by own address bits 9:8 and then R/W = 0. Only the low byte that follows is compared under the mask. After the decision the block ignores further bytes (the data phase) until the bus-reset input reports a stop or a repeated start. The sequencer has three states. IDLE waits for the first byte. LOW_WAIT waits for the 10-bit low byte. DONE ignores bytes. Its transitions are:
- IDLE→LOW_WAIT on a matching 10-bit header.
- IDLE→DONE on any 7-bit address, or on a 10-bit header that does not match.
- LOW_WAIT→DONE on the low byte.
- any state→IDLE on bus reset.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset `ack_valid`, `ack`, `addr_hit`, `rw_bit` and `hit_addr` are all 0, and the sequencer is in IDLE.
- R2: In 7-bit mode (`ten_bit`=0), a byte taken in IDLE matches when, for every bit position n in 7..1, the byte bit equals `own_addr[n]`, or n is in 5..1 and `addr_mask[n-1]` is 1. Bits 7:6 are never masked.
- R3: Byte bit 0 (R/W) takes no part in the 7-bit comparison. For every byte taken in IDLE, `rw_bit` is loaded with byte bit 0.
- R4: In 10-bit mode, the byte taken in IDLE is acknowledged exactly when it equals {5'b11110, `own_addr[9:8]`, 1'b0}. `addr_hit` stays 0 for the header. A non-matching header is NACKed and the sequence moves to DONE, so the following byte is ignored.
- R5: In 10-bit mode, the low byte after an accepted header matches when each bit n in 7..0 equals `own_addr[n]`, or is masked. Bits 5..2 are masked by `addr_mask[n-1]`. Bits 1 and 0 are both masked by `addr_mask[0]`. Bits 7:6 are compared exactly.
- R6: `ack_valid` pulses for exactly one cycle, in the cycle after an accepted strobe. `ack` is 0 whenever `ack_valid` is 0.
- R7: On a full address match, `addr_hit` pulses with `ack_valid` and `hit_addr` is loaded with the received address. In 7-bit mode this is {2'b00, byte[7:1], 1'b0}. In 10-bit mode it is {header[2:1], low byte}. At all other times `hit_addr` holds its value.
- R8: In DONE, strobed bytes produce no `ack_valid`. `bus_reset` returns the sequencer to IDLE, takes priority over a simultaneous strobe, and that strobe produces no decision.
- R9: With `addr_mask`=0, only the single own address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received byte |
| bus_reset | input | 1 | Stop or repeated start seen; returns to IDLE |
| ten_bit | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| own_addr | input | 10 | Own address; 7-bit mode uses bits 7:1 |
| addr_mask | input | 5 | Don't-care mask; element i acts on address bit i+1 |
| ack_valid | output | 1 | Decision strobe, one cycle after the byte strobe |
| ack | output | 1 | Acknowledge decision, qualified by `ack_valid` |
| addr_hit | output | 1 | Full address matched |
| rw_bit | output | 1 | Bit 0 of the first byte of the transfer |
| hit_addr | output | 10 | Received address of the last full match |

## Verification
Every result is registered. A byte presented on one falling edge is sampled at the next rising edge. `ack_valid`, `ack`, `addr_hit`, `rw_bit` and `hit_addr` are then due for the one cycle that ends at the following falling edge. The bench drops the strobe on that falling edge and checks every output there. It checks ignored bytes the same way, one cycle after their strobe, and expects no `ack_valid` and an unchanged `hit_addr`. Bus reset is checked both alone and together with a strobe.

// File: rtl/i2c_amatch_pkg.sv
package i2c_amatch_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int MASK_W = 5;
    localparam logic [4:0] HDR_TAG = 5'b11110;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_LOW_WAIT = 2'd1,
        S_DONE     = 2'd2
    } seq_state_t;
endpackage

// File: rtl/amatch_mask_expand.sv
module amatch_mask_expand #(
    parameter int MASK_W = 5,
    parameter int BYTE_W = 8
) (
    input  logic [MASK_W-1:0] mask,
    input  logic              ten_bit,
    output logic [BYTE_W-1:0] byte_mask
);
    // bit 0: R/W in 7-bit mode (always ignored), shares mask[0] in 10-bit mode
    assign byte_mask[0] = ten_bit ? mask[0] : 1'b1;

    for (genvar i = 1; i < BYTE_W; i++) begin : g_bit
        if (i <= MASK_W) begin : g_masked
            assign byte_mask[i] = mask[i-1];
        end else begin : g_exact
            assign byte_mask[i] = 1'b0;
        end
    end
endmodule

// File: rtl/amatch_masked_eq.sv
module amatch_masked_eq #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] dont_care,
    output logic         equal
);
    assign equal = ~|((a ^ b) & ~dont_care);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_amatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              bus_reset,
    input  logic              ten_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [MASK_W-1:0] addr_mask,
    output logic              ack_valid,
    output logic              ack,
    output logic              addr_hit,
    output logic              rw_bit,
    output logic [ADDR_W-1:0] hit_addr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    seq_state_t state_q, state_d;
    logic [BYTE_W-1:0] low_mask;
    logic [BYTE_W-1:0] hdr_ref;
    logic              low_eq, hdr_eq;
    logic [HI_W-1:0]   hdr_bits_q;
    logic              take;

    assign take    = byte_valid && !bus_reset;
    assign hdr_ref = {HDR_TAG, own_addr[ADDR_W-1:BYTE_W], 1'b0};

    amatch_mask_expand #(.MASK_W(MASK_W), .BYTE_W(BYTE_W)) u_mexp (
        .mask      (addr_mask),
        .ten_bit   (ten_bit),
        .byte_mask (low_mask)
    );

    amatch_masked_eq #(.W(BYTE_W)) u_low_cmp (
        .a         (byte_data),
        .b         (own_addr[BYTE_W-1:0]),
        .dont_care (low_mask),
        .equal     (low_eq)
    );

    amatch_masked_eq #(.W(BYTE_W)) u_hdr_cmp (
        .a         (byte_data),
        .b         (hdr_ref),
        .dont_care ('0),
        .equal     (hdr_eq)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_reset) begin
            state_d = S_IDLE;
        end else if (byte_valid) begin
            unique case (state_q)
                S_IDLE:     state_d = (ten_bit && hdr_eq) ? S_LOW_WAIT : S_DONE;
                S_LOW_WAIT: state_d = S_DONE;
                S_DONE:     state_d = S_DONE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack        <= 1'b0;
            addr_hit   <= 1'b0;
            rw_bit     <= 1'b0;
            hit_addr   <= '0;
            hdr_bits_q <= '0;
        end else begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            addr_hit  <= 1'b0;
            if (take) begin
                unique case (state_q)
                    S_IDLE: begin
                        ack_valid <= 1'b1;
                        rw_bit    <= byte_data[0];
                        if (ten_bit) begin
                            ack        <= hdr_eq;
                            hdr_bits_q <= byte_data[HI_W:1];
                        end else begin
                            ack      <= low_eq;
                            addr_hit <= low_eq;
                            if (low_eq) hit_addr <= {{HI_W{1'b0}}, byte_data[BYTE_W-1:1], 1'b0};
                        end
                    end
                    S_LOW_WAIT: begin
                        ack_valid <= 1'b1;
                        ack       <= low_eq;
                        addr_hit  <= low_eq;
                        if (low_eq) hit_addr <= {hdr_bits_q, byte_data};
                    end
                    S_DONE: ;
                    default: ;
                endcase
            end
        end
    end

    // R6: decision one cycle after an accepted strobe in a deciding state
    p_ack_next_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state_q != S_DONE) |=> ack_valid);
    p_no_strobe_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> !ack_valid);
    p_ack_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |-> !ack);
    // R7: hit only with a positive decision; address held otherwise
    p_hit_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> (ack && ack_valid));
    p_hit_addr_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> $stable(hit_addr));
    // R8: bus reset returns to idle and suppresses decisions
    p_bus_reset_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state_q == S_IDLE && !ack_valid));
    p_done_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && !bus_reset) |=> !ack_valid);
    // R4: header decision never reports a full match
    p_header_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state_q == S_IDLE && ten_bit) |=> !addr_hit);
endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       bus_reset = 1'b0;
    logic       ten_bit = 1'b0;
    logic [9:0] own_addr = '0;
    logic [4:0] addr_mask = '0;
    logic       ack_valid, ack, addr_hit, rw_bit;
    logic [9:0] hit_addr;

    int n_checks = 0;
    int n_fail = 0;
    logic [9:0] exp_hit_addr = '0;
    logic       exp_rw = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_match dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .bus_reset(bus_reset), .ten_bit(ten_bit), .own_addr(own_addr),
        .addr_mask(addr_mask), .ack_valid(ack_valid), .ack(ack),
        .addr_hit(addr_hit), .rw_bit(rw_bit), .hit_addr(hit_addr)
    );

    function automatic bit ref_match7(logic [7:0] b, logic [9:0] own, logic [4:0] m);
        for (int n = 1; n <= 7; n++) begin
            bit dc = (n <= 5) ? m[n-1] : 1'b0;
            if (!dc && b[n] != own[n]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit ref_match10(logic [7:0] b, logic [9:0] own, logic [4:0] m);
        for (int n = 0; n <= 7; n++) begin
            bit dc = (n <= 1) ? m[0] : ((n <= 5) ? m[n-1] : 1'b0);
            if (!dc && b[n] != own[n]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_out(string req, bit v, bit a, bit h);
        check(req, "ack_valid", 32'(ack_valid), 32'(v));
        check(req, "ack", 32'(ack), 32'(a));
        check(req, "addr_hit", 32'(addr_hit), 32'(h));
        check(req, "rw_bit", 32'(rw_bit), 32'(exp_rw));
        check(req, "hit_addr", 32'(hit_addr), 32'(exp_hit_addr));
    endtask

    task automatic pulse_bus_reset();
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        check("R8", "ack_valid after bus_reset", 32'(ack_valid), 32'd0);
    endtask

    // present one byte; outputs checked one cycle later
    task automatic send(logic [7:0] b);
        byte_data = b;
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic do7(logic [7:0] b);
        bit m = ref_match7(b, own_addr, addr_mask);
        send(b);
        exp_rw = b[0];
        if (m) exp_hit_addr = {2'b00, b[7:1], 1'b0};
        check_out(m ? "R2" : "R2_nack", 1'b1, m, m);
        send(b ^ 8'h55);
        check_out("R8", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do10(logic [7:0] hdr, logic [7:0] low);
        bit hm = (hdr == {5'b11110, own_addr[9:8], 1'b0});
        bit lm = ref_match10(low, own_addr, addr_mask);
        send(hdr);
        exp_rw = hdr[0];
        check_out("R4", 1'b1, hm, 1'b0);
        send(low);
        if (hm) begin
            if (lm) exp_hit_addr = {hdr[2:1], low};
            check_out("R5", 1'b1, lm, lm);
        end else begin
            check_out("R8", 1'b0, 1'b0, 1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check_out("R1", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 1'b0, 1'b0, 1'b0);

        // directed 7-bit: own 0xA0, mask 00111
        own_addr = 10'h0A0; addr_mask = 5'b00111; ten_bit = 1'b0;
        pulse_bus_reset(); do7(8'hAE);
        pulse_bus_reset(); do7(8'hA3);        // R3: R/W set, still match
        pulse_bus_reset(); do7(8'hB0);        // bit4 not masked
        pulse_bus_reset(); do7(8'h60);        // bit7 never masked
        // R9 zero mask exact
        addr_mask = 5'b00000;
        pulse_bus_reset(); do7(8'hA2);
        pulse_bus_reset(); do7(8'hA1);
        // directed 10-bit: own 0x2A0, mask 00111
        ten_bit = 1'b1; own_addr = 10'h2A0; addr_mask = 5'b00111;
        pulse_bus_reset(); do10(8'hF4, 8'hAF);
        pulse_bus_reset(); do10(8'hF4, 8'hB0);
        pulse_bus_reset(); do10(8'hF2, 8'hA0); // header mismatch
        pulse_bus_reset(); do10(8'hF5, 8'hA0); // header with R/W=1
        addr_mask = 5'b00001;
        pulse_bus_reset(); do10(8'hF4, 8'hA3); // R5 mask[0] covers bits 1:0
        pulse_bus_reset(); do10(8'hF4, 8'hE0); // bit6 exact
        // R8 bus_reset priority over a simultaneous strobe
        ten_bit = 1'b0; own_addr = 10'h0A0; addr_mask = 5'b00000;
        byte_data = 8'hA0; byte_valid = 1'b1; bus_reset = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0; bus_reset = 1'b0;
        @(negedge clk);
        check_out("R8", 1'b0, 1'b0, 1'b0);
        do7(8'hA0);                            // still in IDLE afterwards

        // random
        for (int t = 0; t < 400; t++) begin
            logic [7:0] b, hdr;
            ten_bit = 1'($urandom);
            own_addr = 10'($urandom);
            addr_mask = 5'($urandom);
            pulse_bus_reset();
            if (!ten_bit) begin
                b = own_addr[7:0] ^ (8'($urandom) & {2'b00, addr_mask, 1'b1});
                if ($urandom_range(3) == 0) b = b ^ (8'h1 << $urandom_range(7));
                do7(b);
            end else begin
                hdr = {5'b11110, own_addr[9:8], 1'b0};
                if ($urandom_range(4) == 0) hdr = hdr ^ (8'h1 << $urandom_range(7));
                b = own_addr[7:0] ^ (8'($urandom) & {2'b00, addr_mask[4:1], {2{addr_mask[0]}}});
                if ($urandom_range(3) == 0) b = b ^ (8'h1 << $urandom_range(7));
                do10(hdr, b);
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule